// File: doc/BRIEF.md
# Single-channel DMA engine

This block is one channel of a direct memory access engine. It copies data units between two addresses, one on the peripheral side and one on the memory side. Each unit is moved by one read transaction followed by one write transaction on a simple valid/ready master port. Software programs the channel through a four-word register port: a control word, a remaining-unit count and the two address pointers. It then sets the enable bit. The channel either waits for a request line from a peripheral before each unit, or, in memory-to-memory mode, runs back to back until the count runs out.

After every unit the count drops by one, and the two pointers advance by the unit size when their step bits are set. The channel signals three events: the midpoint of the buffer, the end of the buffer and a bus error. Each event has its own interrupt enable, and the enabled events are merged onto one interrupt line. In circular mode the count and both pointers return to the values they held when the channel was enabled, and the transfer goes on. In normal mode the channel idles with a count of zero.

Top module: `dmach_top`

## Requirements
- R1: After reset the control word, the count and both pointers read as zero. No bus transaction is issued and no event or interrupt is raised.
- R2: Register index 0 is the control word, with bits: 0 enable, 1 memory-to-memory, 2 circular, 3 direction, 4 peripheral step, 5 memory step, 7:6 peripheral size, 9:8 memory size, 11:10 priority, 12 end interrupt enable, 13 midpoint interrupt enable, 14 error interrupt enable. The control word reads back as written. Register index 1 is the count. A write to it is ignored while the enable bit is set and takes effect while it is clear.
- R3: The count drops by exactly one after each completed unit. In normal mode, when it reaches zero, the channel issues no further transaction and the enable bit stays set.
- R4: With the direction bit clear, each unit reads from the peripheral pointer (register index 2) and writes to the memory pointer (register index 3). With it set, the roles swap. The written data equals the data returned by the read.
- R5: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. After each unit, a pointer whose step bit is set advances by its size in bytes, and a pointer whose step bit is clear keeps its value. Each transaction carries the size code of the pointer it addresses on the size output.
- R6: The midpoint event pulses for one cycle when the count reaches the programmed count divided by two, rounded down. The end event pulses for one cycle when the count reaches zero.
- R7: In circular mode, on reaching zero, the count and both pointers reload the values they held at the enable write, and transfers continue.
- R8: In memory-to-memory mode the channel runs without a request. It ignores the circular bit and gives no request acknowledge.
- R9: An error response ends the current unit. The enable bit is cleared, the error event pulses, the count and pointers keep their values, and no further transaction is issued.
- R10: The interrupt output is high in exactly the cycles in which an event pulses while its enable bit is set.
- R11: Once bus_valid is raised, it stays high with address, direction and write data unchanged until bus_ready is seen.
- R12: Outside memory-to-memory mode, a unit starts only while the request input is high. Each completed unit pulses the acknowledge output once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 control, 1 count, 2 peripheral pointer, 3 memory pointer) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| periph_req | input | 1 | Peripheral request, level |
| periph_ack | output | 1 | One-cycle pulse after each unit in peripheral mode |
| bus_valid | output | 1 | Master transaction valid |
| bus_write | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | AW | Transaction byte address |
| bus_size | output | 2 | Size code of the transaction |
| bus_wdata | output | DW | Write data |
| bus_ready | input | 1 | Slave accepts the transaction this cycle |
| bus_rdata | input | DW | Read data, valid with bus_ready |
| bus_err | input | 1 | Error response, valid with bus_ready |
| evt_tc | output | 1 | End-of-buffer event pulse |
| evt_ht | output | 1 | Midpoint event pulse |
| evt_err | output | 1 | Bus error event pulse |
| irq | output | 1 | Merged interrupt of enabled events |

## Verification
A register write takes effect at the next rising edge, and register reads are combinational. The bench therefore drives a write for one cycle and reads back at a later falling edge. The event, interrupt and acknowledge pulses are registered. They appear in the cycle after the edge at which the write phase or the failing phase is accepted. The bench counts them at every falling edge and compares the totals only after the channel has been idle for eight cycles. The bus slave in the bench raises ready at a falling edge, so each recorded transaction is the one accepted at the next rising edge. Per-unit addresses, sizes and data are checked from that record after the run.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

   localparam int CFG_W = 15;

   typedef struct packed {
      logic       err_ie;
      logic       ht_ie;
      logic       tc_ie;
      logic [1:0] prio;
      logic [1:0] msize;
      logic [1:0] psize;
      logic       minc;
      logic       pinc;
      logic       dir;
      logic       circ;
      logic       m2m;
      logic       en;
   } cfg_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } st_t;

   // bytes per unit for a size code; code 3 is treated as a word
   function automatic logic [2:0] step_bytes(input logic [1:0] sz);
      case (sz)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dmach_cfg.sv
module dmach_cfg
   import dmach_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  cfg_t wdata,
   input  logic err_clr,
   output cfg_t q,
   output logic arm
);

   assign arm = we && wdata.en && !q.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         if (we) q <= wdata;
         if (err_clr) q.en <= 1'b0;
      end
   end

endmodule

// File: rtl/dmach_ptr.sv
module dmach_ptr
   import dmach_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_val,
   input  logic          arm,
   input  logic          step,
   input  logic          inc,
   input  logic [1:0]    size,
   input  logic          rewind,
   output logic [AW-1:0] cur
);

   logic [AW-1:0] base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur  <= '0;
         base <= '0;
      end else begin
         if (arm) base <= cur;
         if (wr_en)             cur <= wr_val;
         else if (rewind)       cur <= base;
         else if (step && inc)  cur <= cur + AW'(step_bytes(size));
      end
   end

   assert_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rewind && !wr_en) |=> (cur == $past(base)));

endmodule

// File: rtl/dmach_cnt.sv
module dmach_cnt #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [CW-1:0] wr_val,
   input  logic          arm,
   input  logic          dec,
   input  logic          circ,
   input  logic          en,
   output logic [CW-1:0] count,
   output logic          evt_tc,
   output logic          evt_ht
);

   logic [CW-1:0] reload;
   logic [CW-1:0] next_cnt;
   logic          live, hit_zero, hit_half;

   assign live     = dec && (count != '0);
   assign next_cnt = count - CW'(1);
   assign hit_zero = (next_cnt == '0);
   assign hit_half = (next_cnt == (reload >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         reload <= '0;
         evt_tc <= 1'b0;
         evt_ht <= 1'b0;
      end else begin
         evt_tc <= live && hit_zero;
         evt_ht <= live && hit_half;
         if (arm) reload <= count;
         if (wr_en)      count <= wr_val;
         else if (live)  count <= (hit_zero && circ) ? reload : next_cnt;
      end
   end

   assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !dec) |=> $stable(count));

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !wr_en && (count > CW'(1))) |=> (count == $past(count) - CW'(1)));

   assert_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_tc |-> ((count == '0) || (count == reload)));

endmodule

// File: rtl/dmach_top.sv
module dmach_top
   import dmach_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          periph_req,
   output logic          periph_ack,
   output logic          bus_valid,
   output logic          bus_write,
   output logic [AW-1:0] bus_addr,
   output logic [1:0]    bus_size,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_ready,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_err,
   output logic          evt_tc,
   output logic          evt_ht,
   output logic          evt_err,
   output logic          irq
);

   localparam int RW     = 32;
   localparam int NPTR   = 2;
   localparam int PTR_IX = 2;

   generate
      if (AW < 8 || AW > RW) begin : g_bad_aw
         $error("dmach_top: AW must lie in 8..32");
      end
      if (CW < 2 || CW > RW) begin : g_bad_cw
         $error("dmach_top: CW must lie in 2..32");
      end
      if (DW < 32 || (DW % 8) != 0) begin : g_bad_dw
         $error("dmach_top: DW must be a byte multiple of at least 32");
      end
   endgenerate

   cfg_t          cfg;
   logic          arm;
   st_t           st;
   logic [DW-1:0] data_q;
   logic          evt_err_q, ack_q;
   logic [CW-1:0] count;
   logic [AW-1:0] ptr_q [NPTR];
   logic          unit_done, err_hit, wrap, circ_eff, launch, dst_side;

   assign circ_eff  = cfg.circ & ~cfg.m2m;
   assign launch    = cfg.en && (count != '0) && (cfg.m2m || periph_req);
   assign err_hit   = (st != ST_IDLE) && bus_ready && bus_err;
   assign unit_done = (st == ST_WR) && bus_ready && !bus_err;
   assign wrap      = unit_done && circ_eff && (count == CW'(1));

   dmach_cfg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we && (reg_addr == 2'd0)),
      .wdata   (cfg_t'(reg_wdata[CFG_W-1:0])),
      .err_clr (err_hit),
      .q       (cfg),
      .arm     (arm)
   );

   dmach_cnt #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_we && (reg_addr == 2'd1) && !cfg.en),
      .wr_val (reg_wdata[CW-1:0]),
      .arm    (arm),
      .dec    (unit_done),
      .circ   (circ_eff),
      .en     (cfg.en),
      .count  (count),
      .evt_tc (evt_tc),
      .evt_ht (evt_ht)
   );

   // index 0: peripheral side, index 1: memory side
   for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
      dmach_ptr #(.AW(AW)) u_ptr (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (reg_we && (reg_addr == 2'(gi + PTR_IX))),
         .wr_val (reg_wdata[AW-1:0]),
         .arm    (arm),
         .step   (unit_done),
         .inc    ((gi == 0) ? cfg.pinc : cfg.minc),
         .size   ((gi == 0) ? cfg.psize : cfg.msize),
         .rewind (wrap),
         .cur    (ptr_q[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         data_q    <= '0;
         evt_err_q <= 1'b0;
         ack_q     <= 1'b0;
      end else begin
         evt_err_q <= err_hit;
         ack_q     <= unit_done && !cfg.m2m;
         case (st)
            ST_IDLE: if (launch) st <= ST_RD;
            ST_RD: if (bus_ready) begin
               if (bus_err) st <= ST_IDLE;
               else begin
                  st     <= ST_WR;
                  data_q <= bus_rdata;
               end
            end
            ST_WR:   if (bus_ready) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // read phase addresses the source side, write phase the other one
   assign bus_valid  = (st != ST_IDLE);
   assign bus_write  = (st == ST_WR);
   assign dst_side   = bus_write ^ cfg.dir;
   assign bus_addr   = dst_side ? ptr_q[1] : ptr_q[0];
   assign bus_size   = dst_side ? cfg.msize : cfg.psize;
   assign bus_wdata  = data_q;
   assign periph_ack = ack_q;
   assign evt_err    = evt_err_q;
   assign irq        = (evt_tc & cfg.tc_ie) | (evt_ht & cfg.ht_ie) | (evt_err_q & cfg.err_ie);

   always_comb begin
      case (reg_addr)
         2'd0:    reg_rdata = RW'(cfg);
         2'd1:    reg_rdata = RW'(count);
         2'd2:    reg_rdata = RW'(ptr_q[0]);
         default: reg_rdata = RW'(ptr_q[1]);
      endcase
   end

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

   assert_err_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_err |-> !cfg.en);

   assert_wait_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_IDLE) && !cfg.m2m && !periph_req) |=> !bus_valid);

endmodule

// File: tb/dmach_tb.sv
`timescale 1ns/1ps
module dmach_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        periph_req = 1'b1;
   logic        periph_ack;
   logic        bus_valid, bus_write;
   logic [31:0] bus_addr;
   logic [1:0]  bus_size;
   logic [31:0] bus_wdata;
   logic        bus_ready, bus_err;
   logic [31:0] bus_rdata;
   logic        evt_tc, evt_ht, evt_err, irq;

   always #4 clk = ~clk;

   dmach_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
      .periph_ack(periph_ack), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .evt_tc(evt_tc), .evt_ht(evt_ht), .evt_err(evt_err), .irq(irq)
   );

   int n_chk = 0, n_fail = 0;
   int rec_n = 0, n_reads = 0, n_writes = 0, err_at = -1;
   int n_tc = 0, n_ht = 0, n_ev_err = 0, n_irq = 0, n_ack = 0;
   logic        rec_wr   [64];
   logic [31:0] rec_addr [64];
   logic [31:0] rec_data [64];
   logic [1:0]  rec_size [64];

   function automatic logic [31:0] pat(input logic [31:0] a);
      return a * 32'h9E37_79B1 + 32'h0000_1111;
   endfunction

   function automatic int stp(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [31:0] mk_cfg(input logic en, m2m, circ, dir, pinc, minc,
                                          input logic [1:0] psz, msz,
                                          input logic tcie, htie, errie);
      return {17'd0, errie, htie, tcie, 2'b00, msz, psz, minc, pinc, dir, circ, m2m, en};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // bus slave: ready decided at the falling edge, accepted at the next rising edge
   initial begin
      bus_ready = 1'b0; bus_err = 1'b0; bus_rdata = '0;
      forever begin
         @(negedge clk);
         bus_ready = 1'b0;
         bus_err   = 1'b0;
         if (bus_valid && ($urandom % 4 != 0) && rec_n < 64) begin
            bus_ready       = 1'b1;
            rec_wr[rec_n]   = bus_write;
            rec_addr[rec_n] = bus_addr;
            rec_size[rec_n] = bus_size;
            rec_data[rec_n] = bus_wdata;
            if (!bus_write) begin
               bus_rdata = pat(bus_addr);
               if (err_at == n_reads) bus_err = 1'b1;
               n_reads++;
            end else begin
               n_writes++;
            end
            rec_n++;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (evt_tc)     n_tc++;
         if (evt_ht)     n_ht++;
         if (evt_err)    n_ev_err++;
         if (irq)        n_irq++;
         if (periph_ack) n_ack++;
      end
   end

   task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic start_run(input logic [31:0] cw, input int n, input logic [31:0] pa, ma);
      reg_wr(2'd0, 32'd0);
      reg_wr(2'd1, 32'(n));
      reg_wr(2'd2, pa);
      reg_wr(2'd3, ma);
      rec_n = 0; n_reads = 0; n_writes = 0;
      n_tc = 0; n_ht = 0; n_ev_err = 0; n_irq = 0; n_ack = 0;
      reg_wr(2'd0, cw | 32'd1);
   endtask

   task automatic wait_writes(input int target);
      int guard;
      guard = 0;
      while (n_writes < target && guard < 3000) begin
         @(negedge clk);
         guard++;
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic check_units(input int units, input int nbuf, input logic [31:0] s0, d0,
                              input int ss, ds, input logic [1:0] ssz, dsz, input string tag);
      for (int k = 0; k < units; k++) begin
         int p;
         int r;
         logic [31:0] sa, da;
         bit ok;
         p  = k % nbuf;
         r  = 2 * k;
         sa = s0 + 32'(p * ss);
         da = d0 + 32'(p * ds);
         ok = (rec_wr[r] == 1'b0) && (rec_addr[r] == sa) && (rec_size[r] == ssz) &&
              (rec_wr[r+1] == 1'b1) && (rec_addr[r+1] == da) && (rec_size[r+1] == dsz) &&
              (rec_data[r+1] == pat(sa));
         check(ok, tag, rec_addr[r+1], da);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v, cw, pa, ma;
      int guard, seen;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 4; i++) begin
         reg_rd(2'(i), v);
         check(v == 32'd0, "R1 register reset", v, 0);
      end
      check(!bus_valid && !irq && !evt_tc && !evt_ht && !evt_err, "R1 idle outputs",
            {bus_valid, irq, evt_tc, evt_ht, evt_err}, 0);

      // directed: peripheral to memory, fixed source, word steps on memory
      pa = 32'h4000_0010; ma = 32'h2000_0100;
      cw = mk_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0);
      start_run(cw, 6, pa, ma);
      wait_writes(6);
      check_units(6, 6, pa, ma, 0, 4, 2'd0, 2'd2, "R4 R5 peripheral to memory");
      reg_rd(2'd1, v);  check(v == 0, "R3 count at end", v, 0);
      check(rec_n == 12, "R3 no activity after end", rec_n, 12);
      check(n_tc == 1 && n_ht == 1, "R6 end and midpoint once", {n_tc[15:0], n_ht[15:0]}, 32'h0001_0001);
      check(n_irq == 1, "R10 only enabled event interrupts", n_irq, 1);
      check(n_ack == 6, "R12 acknowledge per unit", n_ack, 6);
      reg_rd(2'd0, v);  check(v == (cw | 32'd1), "R2 control readback, enable kept R3", v, cw | 32'd1);
      reg_rd(2'd2, v);  check(v == pa, "R5 fixed pointer", v, pa);
      reg_rd(2'd3, v);  check(v == ma + 32'd24, "R5 stepped pointer", v, ma + 32'd24);

      // R2: count writes locked while enabled
      reg_wr(2'd1, 32'd99);
      reg_rd(2'd1, v);  check(v == 0, "R2 count write ignored when enabled", v, 0);
      reg_wr(2'd0, 32'd0);
      reg_wr(2'd1, 32'd5);
      reg_rd(2'd1, v);  check(v == 5, "R2 count write when disabled", v, 5);

      // R4: reversed direction, half-word steps both sides
      cw = mk_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0);
      start_run(cw, 5, pa, ma);
      wait_writes(5);
      check_units(5, 5, ma, pa, 2, 2, 2'd1, 2'd1, "R4 memory to peripheral");
      check(n_ht == 1 && n_tc == 1, "R6 odd length events", {n_tc[15:0], n_ht[15:0]}, 32'h0001_0001);
      check(n_irq == 2, "R10 two enabled events", n_irq, 2);

      // R12: no start without request
      periph_req = 1'b0;
      cw = mk_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      start_run(cw, 3, pa, ma);
      repeat (20) @(negedge clk);
      check(rec_n == 0, "R12 no transaction without request", rec_n, 0);
      reg_rd(2'd1, v);  check(v == 3, "R12 count untouched without request", v, 3);
      periph_req = 1'b1;
      wait_writes(3);
      check_units(3, 3, pa, ma, 1, 1, 2'd0, 2'd0, "R12 runs once requested");

      // R7: circular, stopped after seven units by dropping the request
      cw = mk_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
      start_run(cw, 3, pa, ma);
      seen = 0; guard = 0;
      while (seen < 7 && guard < 3000) begin
         @(negedge clk);
         guard++;
         if (periph_ack) seen++;
      end
      periph_req = 1'b0;
      repeat (8) @(negedge clk);
      check_units(7, 3, pa, ma, 4, 1, 2'd2, 2'd0, "R7 circular wrap addresses");
      reg_rd(2'd1, v);  check(v == 2, "R7 count reloaded", v, 2);
      reg_rd(2'd2, v);  check(v == pa + 32'd4, "R7 peripheral pointer reloaded", v, pa + 32'd4);
      reg_rd(2'd3, v);  check(v == ma + 32'd1, "R7 memory pointer reloaded", v, ma + 32'd1);
      check(n_tc == 2 && n_ht == 2, "R7 R6 events per pass", {n_tc[15:0], n_ht[15:0]}, 32'h0002_0002);
      reg_wr(2'd0, 32'd0);

      // R8: memory-to-memory, circular bit set but ignored, no request
      cw = mk_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 2'd2, 1'b1, 1'b0, 1'b0);
      start_run(cw, 4, pa, ma);
      wait_writes(4);
      repeat (20) @(negedge clk);
      check(rec_n == 8, "R8 stops after one pass", rec_n, 8);
      reg_rd(2'd1, v);  check(v == 0, "R8 count ends at zero", v, 0);
      check(n_ack == 0, "R8 no acknowledge", n_ack, 0);
      check(n_tc == 1, "R8 one end event", n_tc, 1);
      check_units(4, 4, ma, pa, 4, 4, 2'd2, 2'd2, "R8 back to back copy");
      periph_req = 1'b1;

      // R9: error response on the third read
      err_at = 2;
      cw = mk_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
      start_run(cw, 5, pa, ma);
      guard = 0;
      while (n_ev_err == 0 && guard < 3000) begin
         @(negedge clk);
         guard++;
      end
      repeat (12) @(negedge clk);
      err_at = -1;
      check(n_ev_err == 1, "R9 error event", n_ev_err, 1);
      check(n_writes == 2 && rec_n == 5, "R9 halted after error", rec_n, 5);
      reg_rd(2'd1, v);  check(v == 3, "R9 count kept", v, 3);
      reg_rd(2'd0, v);  check(v == cw, "R9 enable cleared", v, cw);
      reg_rd(2'd2, v);  check(v == pa + 32'd2, "R9 pointer kept", v, pa + 32'd2);
      check(n_irq == 1, "R10 error interrupt", n_irq, 1);
      check_units(2, 5, pa, ma, 1, 1, 2'd0, 2'd0, "R9 units before error");

      // random normal-mode runs
      for (int it = 0; it < 8; it++) begin
         logic d, pi, mi, te, he;
         logic [1:0] ps, ms, ssz, dsz;
         int n, ss, ds, exp_irq;
         logic [31:0] s0, d0;
         d  = 1'($urandom % 2);  pi = 1'($urandom % 2); mi = 1'($urandom % 2);
         te = 1'($urandom % 2);  he = 1'($urandom % 2);
         ps = 2'($urandom % 3);  ms = 2'($urandom % 3);
         n  = 1 + int'($urandom % 9);
         pa = 32'h4000_0000 + 32'(($urandom % 256) * 4);
         ma = 32'h2000_0000 + 32'(($urandom % 256) * 4);
         cw = mk_cfg(1'b0, 1'b0, 1'b0, d, pi, mi, ps, ms, te, he, 1'b0);
         start_run(cw, n, pa, ma);
         wait_writes(n);
         s0  = d ? ma : pa;              d0  = d ? pa : ma;
         ss  = d ? (mi ? stp(ms) : 0) : (pi ? stp(ps) : 0);
         ds  = d ? (pi ? stp(ps) : 0) : (mi ? stp(ms) : 0);
         ssz = d ? ms : ps;              dsz = d ? ps : ms;
         check_units(n, n, s0, d0, ss, ds, ssz, dsz, "R4 R5 random run");
         reg_rd(2'd1, v);  check(v == 0, "R3 random count end", v, 0);
         check(n_tc == 1 && n_ht == 1, "R6 random events", {n_tc[15:0], n_ht[15:0]}, 32'h0001_0001);
         exp_irq = (n == 1) ? int'(te | he) : int'(te) + int'(he);
         check(n_irq == exp_irq, "R10 random interrupt count", n_irq, exp_irq);
         check(n_ack == n, "R12 random acknowledges", n_ack, n);
      end

      $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
      $finish;
   end

endmodule